// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider Chain

This block is a synchronous model of the feedback divider of an integer-N frequency synthesizer. A prescaler counter that divides by 10 or 11 runs on the input clock. A main counter counts prescaler periods. A swallow counter holds the prescaler at divide-by-11 for the first part of every output cycle. Together they give one output pulse every 10*(M+1)+A input cycles. A bypass mode skips the prescaler, so the main counter counts input cycles directly.

New divider settings are taken only when a division cycle closes, so a setting change never shortens or stretches the cycle in progress. A load strobe restarts the chain at once with the current settings. Two debug select bits put either the modulus-select signal or the raw prescaler pulse on a shared debug output. A disable bit holds the divided output low while the counters keep running.

Top module: `swallow_div_chain`

## Requirements
- R1: With the prescaler in use (`pre_bypass_i` = 0), `fp_o` pulses once every 10*(M+1)+A clock cycles, where M = `m_val_i` (M >= 1) and A = `a_val_i`.
- R2: A swallow value above M+1 is treated as M+1. For example, M=3 with A=15 gives a period of 44.
- R3: With `pre_bypass_i` = 1, the period is M+1 clock cycles and A has no effect. The prescaler is idle, so `pre_o` and `msel_o` stay low.
- R4: `fp_o` is high for exactly the last clock cycle of each division cycle. In prescaler mode it is low in the cycle that follows.
- R5: M, A and the bypass bit are sampled only at the clock edge that ends a division cycle. A change in the middle of a cycle takes effect from the next cycle.
- R6: If `load_i` is high at a clock edge, that edge samples the settings and restarts the division. The next `fp_o` pulse then appears in the N-th cycle after that edge, where N is the new period.
- R7: `msel_o` is high for the first A prescaler periods of every output cycle, each 11 cycles long, so it is high for 11*A cycles per period.
- R8: `dbg_o` follows `pre_o` (a one-cycle pulse at the end of each prescaler period, M+1 pulses per output period) when `pre_dbg_i` = 1. It follows `msel_o` when only `msel_dbg_i` = 1, and it is 0 when both select bits are 0.
- R9: `fp_dis_i` = 1 holds `fp_o` low while counting continues. Once the bit is cleared, pulses resume at the programmed period.
- R10: While `rst_ni` is low, the chain is held at a division boundary: `fp_o` = 1, `msel_o` = 0, `pre_o` = 0. The first edge after reset is released samples the settings, so the first period already follows the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_val_i | input | 9 | Main counter setting M |
| a_val_i | input | 4 | Swallow counter setting A |
| pre_bypass_i | input | 1 | 1: bypass the prescaler |
| load_i | input | 1 | Immediate reload and restart |
| msel_dbg_i | input | 1 | Route modulus select to `dbg_o` |
| pre_dbg_i | input | 1 | Route raw prescaler pulse to `dbg_o` (has priority) |
| fp_dis_i | input | 1 | Hold `fp_o` low |
| fp_o | output | 1 | Divided output pulse |
| msel_o | output | 1 | Modulus select, 1 = divide by 11 |
| pre_o | output | 1 | Raw prescaler end-of-period pulse |
| dbg_o | output | 1 | Selected debug signal |

## Verification
All outputs are decoded from registered count state, so each one reflects the count of the current cycle. `fp_o` is high during the last cycle of a period. A setting or a `load_i` value present at an edge governs the cycles that begin at that edge, so a restart by load gives its first `fp_o` pulse N samples later. The bench drives inputs and samples outputs 1 ns after each rising edge. It measures each period as the number of samples from one `fp_o` pulse to the next, and counts `msel_o` and `dbg_o` over exactly those samples. Settings changed before a wait therefore apply to the period that is measured.

// File: rtl/swdiv_pkg.sv
`timescale 1ns/1ps
package swdiv_pkg;
  localparam int unsigned DEF_M_W    = 9;
  localparam int unsigned DEF_A_W    = 4;
  localparam int unsigned DEF_PSC_LO = 10;

  typedef enum logic {
    MODE_PSC    = 1'b0,
    MODE_BYPASS = 1'b1
  } div_mode_e;
endpackage

// File: rtl/swdiv_cfg.sv
`timescale 1ns/1ps
module swdiv_cfg
  import swdiv_pkg::*;
#(
  parameter int unsigned M_W = DEF_M_W,
  parameter int unsigned A_W = DEF_A_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reload_i,
  input  logic [M_W-1:0] m_val_i,
  input  logic [A_W-1:0] a_val_i,
  input  logic           bypass_i,
  output logic [M_W-1:0] act_m_o,
  output div_mode_e      mode_o,
  output logic [A_W-1:0] a_start_o
);
  localparam int unsigned CW = (M_W + 1 > A_W) ? M_W + 1 : A_W;

  logic [CW-1:0]  m_span;
  logic [CW-1:0]  a_ext;
  logic [M_W-1:0] act_m_q;
  div_mode_e      mode_q;

  assign m_span = CW'(m_val_i) + CW'(1);
  assign a_ext  = CW'(a_val_i);

  // swallow count limited to M+1; zero in bypass
  always_comb begin
    if (bypass_i)            a_start_o = '0;
    else if (a_ext > m_span) a_start_o = m_span[A_W-1:0];
    else                     a_start_o = a_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_m_q <= '0;
      mode_q  <= MODE_BYPASS;
    end else if (reload_i) begin
      act_m_q <= m_val_i;
      mode_q  <= bypass_i ? MODE_BYPASS : MODE_PSC;
    end
  end

  assign act_m_o = act_m_q;
  assign mode_o  = mode_q;

  p_hold_mid_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> ($stable(act_m_q) && $stable(mode_q)));
endmodule

// File: rtl/swdiv_psc.sv
`timescale 1ns/1ps
module swdiv_psc
  import swdiv_pkg::*;
#(
  parameter int unsigned LO = DEF_PSC_LO
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic wide_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = $clog2(LO + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = wide_i ? CNT_W'(LO) : CNT_W'(LO - 1);
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (restart_i || !run_i || tick_o)  cnt_q <= '0;
    else                                     cnt_q <= cnt_q + CNT_W'(1);
  end

  p_psc_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LO));
endmodule

// File: rtl/swdiv_cnt.sv
`timescale 1ns/1ps
module swdiv_cnt
  import swdiv_pkg::*;
#(
  parameter int unsigned M_W = DEF_M_W,
  parameter int unsigned A_W = DEF_A_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  div_mode_e      mode_i,
  input  logic [M_W-1:0] act_m_i,
  input  logic [A_W-1:0] a_start_i,
  input  logic           tick_i,
  input  logic           restart_i,
  output logic           end_o,
  output logic           msel_o
);
  localparam int unsigned CW = (M_W + 1 > A_W) ? M_W + 1 : A_W;

  logic [M_W-1:0] m_cnt_q;
  logic [A_W-1:0] a_cnt_q;
  logic           step;
  logic [CW-1:0]  room;

  assign step   = (mode_i == MODE_BYPASS) || tick_i;
  assign end_o  = step && (m_cnt_q == act_m_i);
  assign msel_o = (a_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt_q <= '0;
      a_cnt_q <= '0;
    end else if (restart_i) begin
      m_cnt_q <= '0;
      a_cnt_q <= a_start_i;
    end else if (step) begin
      m_cnt_q <= m_cnt_q + M_W'(1);
      if (a_cnt_q != '0) a_cnt_q <= a_cnt_q - A_W'(1);
    end
  end

  // prescaler periods still left in this cycle
  assign room = CW'(act_m_i) + CW'(1) - CW'(m_cnt_q);

  p_swallow_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(a_cnt_q) <= room);

  p_fp_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && mode_i == MODE_PSC) |=> (!end_o || mode_i == MODE_BYPASS));
endmodule

// File: rtl/swallow_div_chain.sv
`timescale 1ns/1ps
module swallow_div_chain
  import swdiv_pkg::*;
#(
  parameter int unsigned M_W    = DEF_M_W,
  parameter int unsigned A_W    = DEF_A_W,
  parameter int unsigned PSC_LO = DEF_PSC_LO
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] m_val_i,
  input  logic [A_W-1:0] a_val_i,
  input  logic           pre_bypass_i,
  input  logic           load_i,
  input  logic           msel_dbg_i,
  input  logic           pre_dbg_i,
  input  logic           fp_dis_i,
  output logic           fp_o,
  output logic           msel_o,
  output logic           pre_o,
  output logic           dbg_o
);
  logic [M_W-1:0] act_m;
  logic [A_W-1:0] a_start;
  div_mode_e      mode;
  logic           tick;
  logic           div_end;
  logic           msel;
  logic           restart;

  assign restart = div_end || load_i;

  swdiv_cfg #(.M_W(M_W), .A_W(A_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reload_i  (restart),
    .m_val_i   (m_val_i),
    .a_val_i   (a_val_i),
    .bypass_i  (pre_bypass_i),
    .act_m_o   (act_m),
    .mode_o    (mode),
    .a_start_o (a_start)
  );

  swdiv_psc #(.LO(PSC_LO)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (mode == MODE_PSC),
    .restart_i (restart),
    .wide_i    (msel),
    .tick_o    (tick)
  );

  swdiv_cnt #(.M_W(M_W), .A_W(A_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .act_m_i   (act_m),
    .a_start_i (a_start),
    .tick_i    (tick),
    .restart_i (restart),
    .end_o     (div_end),
    .msel_o    (msel)
  );

  assign fp_o   = div_end && !fp_dis_i;
  assign msel_o = msel;
  assign pre_o  = tick;

  always_comb begin
    if (pre_dbg_i)       dbg_o = tick;
    else if (msel_dbg_i) dbg_o = msel;
    else                 dbg_o = 1'b0;
  end

  p_bypass_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_BYPASS) |-> (!pre_o && !msel_o));
endmodule

// File: tb/tb_swallow_div_chain.sv
`timescale 1ns/1ps
module tb_swallow_div_chain;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] m_val = 9'd1;
  logic [3:0] a_val = 4'd0;
  logic       byp = 1'b0, load = 1'b0, msel_dbg = 1'b0, pre_dbg = 1'b1, fp_dis = 1'b0;
  logic       fp_o, msel_o, pre_o, dbg_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  swallow_div_chain dut (
    .clk_i(clk), .rst_ni(rst_ni), .m_val_i(m_val), .a_val_i(a_val),
    .pre_bypass_i(byp), .load_i(load), .msel_dbg_i(msel_dbg), .pre_dbg_i(pre_dbg),
    .fp_dis_i(fp_dis), .fp_o(fp_o), .msel_o(msel_o), .pre_o(pre_o), .dbg_o(dbg_o)
  );

  // {bypass, M, A, period, msel cycles, prescaler pulses}
  localparam int VEC [9][6] = '{
    '{0, 1,  0, 20,  0, 2},
    '{0, 1,  2, 22, 22, 2},
    '{0, 8,  0, 90,  0, 9},
    '{0, 8,  9, 99, 99, 9},
    '{0, 5,  3, 63, 33, 6},
    '{0, 3, 15, 44, 44, 4},
    '{0, 2,  2, 32, 22, 3},
    '{1, 4,  3,  5,  0, 0},
    '{1, 0,  0,  1,  0, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_fp();
    for (int i = 0; i < 8000; i++) begin
      step();
      if (fp_o) break;
    end
  endtask

  task automatic measure(output int per, output int ms, output int dg);
    per = 0; ms = 0; dg = 0;
    wait_fp();
    do begin
      step();
      per++;
      ms += int'(msel_o);
      dg += int'(dbg_o);
    end while (!fp_o && per < 8000);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int per, ms, dg, cnt;
    repeat (3) step();
    // R10: state held during reset
    chk("R10 fp_o in reset", int'(fp_o), 1);
    chk("R10 msel_o in reset", int'(msel_o), 0);
    chk("R10 pre_o in reset", int'(pre_o), 0);
    rst_ni = 1'b1;
    cnt = 0;
    do begin step(); cnt++; end while (!fp_o && cnt < 200);
    chk("R10 first period after reset", cnt, 20);

    // R1 R2 R3 R7 R8: vector table
    foreach (VEC[i]) begin
      byp   = VEC[i][0][0];
      m_val = 9'(VEC[i][1]);
      a_val = 4'(VEC[i][2]);
      measure(per, ms, dg);
      chk(VEC[i][0] != 0 ? "R3 bypass period" : (VEC[i][2] > VEC[i][1] + 1 ? "R2 clamped period" : "R1 period"),
          per, VEC[i][3]);
      chk("R7 msel cycles", ms, VEC[i][4]);
      chk(VEC[i][0] != 0 ? "R3 prescaler idle" : "R8 prescaler pulses", dg, VEC[i][5]);
    end

    // R8: debug select
    byp = 1'b0; m_val = 9'd2; a_val = 4'd2;
    pre_dbg = 1'b0; msel_dbg = 1'b1;
    measure(per, ms, dg);
    chk("R8 dbg follows msel", dg, 22);
    msel_dbg = 1'b0;
    measure(per, ms, dg);
    chk("R8 dbg off", dg, 0);
    pre_dbg = 1'b1; msel_dbg = 1'b1;
    measure(per, ms, dg);
    chk("R8 prescaler priority", dg, 3);
    msel_dbg = 1'b0;

    // R4: single-cycle pulse
    m_val = 9'd1; a_val = 4'd0;
    measure(per, ms, dg);
    chk("R4 fp high at end", int'(fp_o), 1);
    step();
    chk("R4 fp low after", int'(fp_o), 0);

    // R5: mid-cycle change
    m_val = 9'd8;
    measure(per, ms, dg);
    cnt = 0;
    repeat (10) begin step(); cnt++; end
    m_val = 9'd1;
    do begin step(); cnt++; end while (!fp_o && cnt < 500);
    chk("R5 current period kept", cnt, 90);
    cnt = 0;
    do begin step(); cnt++; end while (!fp_o && cnt < 500);
    chk("R5 new period after boundary", cnt, 20);

    // R6: load restart
    m_val = 9'd8;
    measure(per, ms, dg);
    wait_fp();
    repeat (30) step();
    m_val = 9'd1; load = 1'b1;
    cnt = 0;
    step(); cnt++;
    load = 1'b0;
    while (!fp_o && cnt < 500) begin step(); cnt++; end
    chk("R6 restart period", cnt, 20);

    // R9: output disable
    fp_dis = 1'b1;
    cnt = 0; dg = 0;
    repeat (100) begin
      step();
      cnt += int'(fp_o);
      dg  += int'(dbg_o);
    end
    chk("R9 fp held low", cnt, 0);
    chk("R9 counting continues", dg, 10);
    fp_dis = 1'b0;
    measure(per, ms, dg);
    chk("R9 period after enable", per, 20);

    summary();
    $finish;
  end
endmodule